// File: doc/BRIEF.md
# Lane-Striped Register File with Rotating Misroute Buffer

This block stores a vector machine's registers in four independent lane banks. Register n belongs to lane n mod 4 and sits in row n / 4 of that bank. Each execution lane has its own write port and its own read port. A result whose destination register lies in the writer's own lane is stored directly, and all four lanes can do this in the same cycle without affecting one another.

A result aimed at another lane's bank does not cross a switch. It is placed into a four-slot ring that moves one lane position per clock. When the entry reaches the slot of its destination lane, it is written into that bank. The cost is one extra cycle for each lane hop, so the worst case is three extra cycles. A direct write to a bank takes priority over a ring entry that arrives there in the same cycle. The losing entry goes once more around the ring.

A lane accepts a misrouted result only when the ring slot at its own position is empty. Otherwise it signals not-ready and the producer keeps the result.

Top module: `lane_striped_rf`

## Requirements
- R1: Register index n (7 bits) maps to lane n[1:0] and row n[6:2]. A read port addresses a row of its own lane's bank only.
- R2: A write on lane s to a register whose lane bits equal s is stored at that clock edge. A read issued in the following cycle returns the new value.
- R3: All four lanes can write directly and read in the same cycle with no interaction between them.
- R4: A write on lane s to a register of lane t≠s enters the ring. It is stored d cycles after a direct write would have been, where d = (t − s) mod 4 is 1, 2 or 3.
- R5: When a direct write and an arriving ring entry target the same bank in one cycle, the direct write is stored. The ring entry makes one more full turn, which adds 4 cycles.
- R6: wr_ready[s] is low exactly while the ring slot at lane s holds an entry. A misrouted write presented while wr_ready[s] is low is ignored. Direct writes are always taken.
- R7: The read port is registered. rd_data[s] shows, one cycle later, the row that rd_row[s] addressed, as the row stood before that edge.
- R8: Reset clears every register and empties the ring, so wr_ready is all ones afterwards. Reset asserts asynchronously and is released synchronously after two clock edges.
- R9: A ring entry that is not stored moves to the next lane slot on the next cycle with its register index and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_valid | input | 4 | Per-lane write request |
| wr_reg | input | 4x7 | Per-lane destination register index |
| wr_data | input | 4x64 | Per-lane write data |
| wr_ready | output | 4 | Per-lane: misrouted write can be accepted |
| rd_row | input | 4x5 | Per-lane read row within the lane's bank |
| rd_data | output | 4x64 | Per-lane registered read data |

## Verification
A ring slot whose valid bit sticks shows at once as a wr_ready bit that stays low beyond the three cycles any entry needs to leave. A lost or misdirected entry shows when a polled read never returns the written value within d + 1 cycles, or returns it in the wrong bank. A wrong priority or a wrong hop count shifts the cycle in which a polled read first sees the value, and each such shift is measured exactly. Registers that reset fails to clear show in the first reads after reset.

// File: rtl/lsrf_pkg.sv
package lsrf_pkg;
  // How a lane's write request is handled this cycle
  typedef enum logic [1:0] {
    ROUTE_IDLE   = 2'd0,
    ROUTE_DIRECT = 2'd1,
    ROUTE_RING   = 2'd2,
    ROUTE_HOLD   = 2'd3
  } route_e;
endpackage

// File: rtl/lsrf_bank.sv
module lsrf_bank #(
  parameter int ROWS = 32,
  parameter int W    = 64,
  localparam int RB  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [RB-1:0] wr_row,
  input  logic [W-1:0]  wr_data,
  input  logic [RB-1:0] rd_row,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= mem[rd_row];
      if (we) mem[wr_row] <= wr_data;
    end
  end

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(wr_row)] == $past(wr_data));

  p_read_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_data == $past(mem[rd_row]));
endmodule

// File: rtl/lsrf_ring.sv
module lsrf_ring #(
  parameter int LANES = 4,
  parameter int IW    = 7,
  parameter int W     = 64,
  localparam int LB   = $clog2(LANES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            inj_valid,
  input  logic [LANES-1:0][IW-1:0]    inj_reg,
  input  logic [LANES-1:0][W-1:0]     inj_data,
  input  logic [LANES-1:0]            bank_busy,
  output logic [LANES-1:0]            inj_ready,
  output logic [LANES-1:0]            exit_valid,
  output logic [LANES-1:0][IW-LB-1:0] exit_row,
  output logic [LANES-1:0][W-1:0]     exit_data
);
  logic [LANES-1:0]         slot_v, nxt_v;
  logic [LANES-1:0][IW-1:0] slot_reg, nxt_reg;
  logic [LANES-1:0][W-1:0]  slot_data, nxt_data;

  // Outputs from the slot parked at each lane
  always_comb begin
    for (int p = 0; p < LANES; p++) begin
      exit_valid[p] = slot_v[p] && (slot_reg[p][LB-1:0] == LB'(p)) && !bank_busy[p];
      exit_row[p]   = slot_reg[p][IW-1:LB];
      exit_data[p]  = slot_data[p];
      inj_ready[p]  = !slot_v[p];
    end
  end

  // Next state: each slot takes the entry from the previous lane, else an injection there
  always_comb begin
    for (int p = 0; p < LANES; p++) begin
      int  src;
      logic pass;
      src         = (p + LANES - 1) % LANES;
      pass        = slot_v[src] && !exit_valid[src];
      nxt_v[p]    = pass || inj_valid[src];
      nxt_reg[p]  = pass ? slot_reg[src]  : inj_reg[src];
      nxt_data[p] = pass ? slot_data[src] : inj_data[src];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_v <= '0;
    else        slot_v <= nxt_v;
  end

  // Payload flops load only when a valid entry moves in
  always_ff @(posedge clk) begin
    for (int p = 0; p < LANES; p++) begin
      if (nxt_v[p]) begin
        slot_reg[p]  <= nxt_reg[p];
        slot_data[p] <= nxt_data[p];
      end
    end
  end

  for (genvar p = 0; p < LANES; p++) begin : g_chk
    localparam int NX = (p + 1) % LANES;

    p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
      slot_v[p] && !exit_valid[p] |=> slot_v[NX] && slot_reg[NX] == $past(slot_reg[p])
                                      && slot_data[NX] == $past(slot_data[p]));

    p_inject_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !inj_ready[p] |-> !inj_valid[p]);

    p_inject_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
      inj_valid[p] |=> slot_v[NX] && slot_reg[NX] == $past(inj_reg[p]));
  end
endmodule

// File: rtl/lane_striped_rf.sv
module lane_striped_rf #(
  parameter int LANES = 4,
  parameter int ROWS  = 32,
  parameter int W     = 64,
  localparam int LB   = $clog2(LANES),
  localparam int RB   = $clog2(ROWS),
  localparam int IW   = LB + RB
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         wr_valid,
  input  logic [LANES-1:0][IW-1:0] wr_reg,
  input  logic [LANES-1:0][W-1:0]  wr_data,
  output logic [LANES-1:0]         wr_ready,
  input  logic [LANES-1:0][RB-1:0] rd_row,
  output logic [LANES-1:0][W-1:0]  rd_data
);
  import lsrf_pkg::*;

  // Asynchronous assert, release after two edges
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  route_e [LANES-1:0]          route;
  logic   [LANES-1:0]          direct_we, inj_valid, ring_ready, exit_valid;
  logic   [LANES-1:0][RB-1:0]  exit_row;
  logic   [LANES-1:0][W-1:0]   exit_data;

  always_comb begin
    for (int s = 0; s < LANES; s++) begin
      if (!wr_valid[s])                        route[s] = ROUTE_IDLE;
      else if (wr_reg[s][LB-1:0] == LB'(s))    route[s] = ROUTE_DIRECT;
      else if (ring_ready[s])                  route[s] = ROUTE_RING;
      else                                     route[s] = ROUTE_HOLD;
      direct_we[s] = (route[s] == ROUTE_DIRECT);
      inj_valid[s] = (route[s] == ROUTE_RING);
    end
  end

  assign wr_ready = ring_ready;

  lsrf_ring #(.LANES(LANES), .IW(IW), .W(W)) u_ring (
    .clk       (clk),
    .rst_n     (rst_q),
    .inj_valid (inj_valid),
    .inj_reg   (wr_reg),
    .inj_data  (wr_data),
    .bank_busy (direct_we),
    .inj_ready (ring_ready),
    .exit_valid(exit_valid),
    .exit_row  (exit_row),
    .exit_data (exit_data)
  );

  for (genvar s = 0; s < LANES; s++) begin : g_lane
    logic          bank_we;
    logic [RB-1:0] bank_row;
    logic [W-1:0]  bank_data;

    // Direct path wins the bank's single write port
    always_comb begin
      bank_we   = direct_we[s] || exit_valid[s];
      bank_row  = direct_we[s] ? wr_reg[s][IW-1:LB] : exit_row[s];
      bank_data = direct_we[s] ? wr_data[s]         : exit_data[s];
    end

    lsrf_bank #(.ROWS(ROWS), .W(W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_q),
      .we     (bank_we),
      .wr_row (bank_row),
      .wr_data(bank_data),
      .rd_row (rd_row[s]),
      .rd_data(rd_data[s])
    );
  end
endmodule

// File: tb/lane_striped_rf_test.sv
module lane_striped_rf_test;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [3:0]       wr_valid;
  logic [3:0][6:0]  wr_reg;
  logic [3:0][63:0] wr_data;
  logic [3:0]       wr_ready;
  logic [3:0][4:0]  rd_row;
  logic [3:0][63:0] rd_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  lane_striped_rf uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_reg(wr_reg),
    .wr_data(wr_data), .wr_ready(wr_ready), .rd_row(rd_row), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  typedef struct { int r; logic [63:0] d; string req; } exp_t;
  exp_t sbq[$];

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_exp(input int r, input logic [63:0] d, input string req);
    exp_t e;
    e.r = r; e.d = d; e.req = req;
    sbq.push_back(e);
  endtask

  // All tasks begin and end just after a falling edge
  task automatic read_reg(input int r, output logic [63:0] d);
    rd_row[r % 4] = 5'(r / 4);
    @(posedge clk); @(negedge clk);
    d = rd_data[r % 4];
  endtask

  task automatic drain();
    logic [63:0] d;
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      read_reg(e.r, d);
      check(d == e.d, {e.req, " R1 stored value"}, d, e.d);
    end
  endtask

  // Write from lane src, then poll the destination: n = edges until the value is seen
  task automatic measure(input int src, input int r, input logic [63:0] d, output int n);
    wr_valid[src] = 1'b1; wr_reg[src] = 7'(r); wr_data[src] = d;
    rd_row[r % 4] = 5'(r / 4);
    @(posedge clk); @(negedge clk);
    wr_valid[src] = 1'b0;
    n = -1;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); @(negedge clk);
      if (n < 0 && rd_data[r % 4] == d) n = k;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [63:0] d;
    int n;
    wr_valid = '0; wr_reg = '0; wr_data = '0; rd_row = '0;
    rst_n = 1'b0;
    @(negedge clk);
    do_reset();

    // R8: reset state
    check(wr_ready == 4'hF, "R8 ready after reset", 64'(wr_ready), 64'hF);
    read_reg(0, d);   check(d == 0, "R8 reg0 cleared", d, 0);
    read_reg(5, d);   check(d == 0, "R8 reg5 cleared", d, 0);
    read_reg(127, d); check(d == 0, "R8 reg127 cleared", d, 0);

    // R2: direct write visible to the next read
    measure(2, 6, 64'h1111_2222_3333_4444, n);
    check(n == 1, "R2 direct latency", 64'(n), 1);
    push_exp(6, 64'h1111_2222_3333_4444, "R2");

    // R3 / R7: four direct writes, then four reads, each in one cycle
    for (int s = 0; s < 4; s++) begin
      wr_valid[s] = 1'b1; wr_reg[s] = 7'(32 + 5 * s); wr_data[s] = 64'hA000 + 64'(s);
    end
    @(posedge clk); @(negedge clk);
    wr_valid = '0;
    for (int s = 0; s < 4; s++) rd_row[s] = 5'(8 + s);
    @(posedge clk); @(negedge clk);
    for (int s = 0; s < 4; s++)
      check(rd_data[s] == 64'hA000 + 64'(s), "R3 R7 parallel lane read", rd_data[s], 64'hA000 + 64'(s));

    // R4: hop distance 1, 2, 3 from lane 1
    measure(1, 42, 64'hB001, n); check(n == 2, "R4 one hop", 64'(n), 2);
    measure(1, 43, 64'hB002, n); check(n == 3, "R4 two hops", 64'(n), 3);
    measure(1, 44, 64'hB003, n); check(n == 4, "R4 three hops", 64'(n), 4);
    push_exp(42, 64'hB001, "R4"); push_exp(43, 64'hB002, "R4"); push_exp(44, 64'hB003, "R4");

    // R5: ring entry meets a direct write at lane 1 and circulates
    wr_valid[0] = 1'b1; wr_reg[0] = 7'd49; wr_data[0] = 64'hC0DE;
    rd_row[1] = 5'd12;
    @(posedge clk); @(negedge clk);
    wr_valid[0] = 1'b0;
    wr_valid[1] = 1'b1; wr_reg[1] = 7'd53; wr_data[1] = 64'hD1D1;
    n = -1;
    for (int k = 1; k <= 12; k++) begin
      @(posedge clk); @(negedge clk);
      wr_valid[1] = 1'b0;
      if (n < 0 && rd_data[1] == 64'hC0DE) n = k;
    end
    check(n == 6, "R5 blocked entry extra turn", 64'(n), 6);
    push_exp(53, 64'hD1D1, "R5");

    // R6: back-pressure follows the entry around the ring
    wr_valid[0] = 1'b1; wr_reg[0] = 7'd59; wr_data[0] = 64'hE059;
    @(posedge clk); @(negedge clk);
    wr_valid[0] = 1'b0;
    check(wr_ready == 4'b1101, "R6 slot1 busy", 64'(wr_ready), 64'b1101);
    wr_valid[1] = 1'b1; wr_reg[1] = 7'd14; wr_data[1] = 64'hBAD0;
    @(posedge clk); @(negedge clk);
    wr_valid[1] = 1'b0;
    check(wr_ready == 4'b1011, "R6 slot2 busy", 64'(wr_ready), 64'b1011);
    @(posedge clk); @(negedge clk);
    check(wr_ready == 4'b0111, "R6 slot3 busy", 64'(wr_ready), 64'b0111);
    @(posedge clk); @(negedge clk);
    check(wr_ready == 4'hF, "R6 ring empty again", 64'(wr_ready), 64'hF);
    repeat (6) @(negedge clk);
    read_reg(14, d); check(d == 0, "R6 write held off while not ready ignored", d, 0);
    push_exp(59, 64'hE059, "R6");

    // R4 / R9: all four lanes inject two-hop results in one cycle
    for (int s = 0; s < 4; s++) begin
      wr_valid[s] = 1'b1; wr_reg[s] = 7'(4 * (20 + s) + ((s + 2) % 4)); wr_data[s] = 64'hF000 + 64'(s);
    end
    @(posedge clk); @(negedge clk);
    wr_valid = '0;
    check(wr_ready == 4'h0, "R6 R9 all slots occupied", 64'(wr_ready), 0);
    @(posedge clk); @(negedge clk);
    check(wr_ready == 4'h0, "R9 entries advanced", 64'(wr_ready), 0);
    @(posedge clk); @(negedge clk);
    check(wr_ready == 4'hF, "R4 all exited after two hops", 64'(wr_ready), 64'hF);
    for (int s = 0; s < 4; s++)
      push_exp(4 * (20 + s) + ((s + 2) % 4), 64'hF000 + 64'(s), "R9");

    // Monitor: compare every stored result against the expectation queue
    drain();

    // R8: reset with an entry in flight
    wr_valid[0] = 1'b1; wr_reg[0] = 7'd102; wr_data[0] = 64'h7777;
    @(posedge clk); @(negedge clk);
    wr_valid[0] = 1'b0;
    do_reset();
    check(wr_ready == 4'hF, "R8 ring emptied by reset", 64'(wr_ready), 64'hF);
    repeat (4) @(negedge clk);
    read_reg(102, d); check(d == 0, "R8 in-flight entry discarded", d, 0);
    read_reg(32, d);  check(d == 0, "R8 stored register cleared", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule